// File: doc/BRIEF.md
# Write-Locked Real-Time Clock Registers

This block is the register side of a real-time clock. A byte-wide bus reaches a seconds counter, a staged copy of a new time value, an alarm value, a control byte, interrupt enable and status bytes, and a backup byte. The backup byte survives a soft reset of everything else. The seconds tick comes from outside as a one-cycle pulse. The clock-error condition also arrives as an input. The block drives an interrupt line and one multi-purpose pin.

Every bus write is dropped unless the key register already holds the unlock value. Software writes the key, writes the registers it needs, and then writes zero to the key to lock the block again. Each 32-bit value is spread over four byte registers, four addresses apart, least significant byte at the lowest address. A new time reaches the counter only through an explicit load strobe. The live counter can be read as one 32-bit word. Reads are never blocked by the lock.

Top module: `rtc_keyreg`

## Requirements
- R1: A write to any address other than the key register (0x0FC) takes effect only while the key register holds 0xAC. A write of any other value to the key register locks the block again. Writes made while locked are dropped without effect.
- R2: The staged time bytes at 0x020, 0x024, 0x028 and 0x02C, and the alarm bytes at 0x030 to 0x03C, form 32-bit values with the least significant byte at the lowest address. Each of these bytes reads back its last written value. The control byte (0x000) and the interrupt enable byte (0x008) also read back their last written values.
- R3: An unlocked write with bit 0 set to the load register (0x004) copies the staged 32-bit time into the counter. The counter reads as one 32-bit word at 0x800.
- R4: When a tick pulse arrives while control bit 0 is set, the counter advances by exactly one. Without control bit 0, the counter holds. If a load and a tick fall in the same cycle, the load wins.
- R5: If a tick advances the counter to the alarm value while control bit 2 is set, status bit 0 is set. If the pin mode (control bits 5:4) is 2 at that moment, status bit 1 is also set. With control bit 2 clear, no status bit is set.
- R6: Status bit 2 is set in any cycle in which the clock-error input is high. It stays set after the input falls.
- R7: Writing a 1 to a bit of the status byte (0x00C) clears that bit. A set event and a clear of the same bit in the same cycle leave the bit set.
- R8: The interrupt output is high exactly when status bit 0 has enable bit 0 set, or status bit 2 has enable bit 2 set.
- R9: In pin mode 2 the pin shows status bit 1. In pin mode 3 it follows the 32 kHz clock input. In every other mode it is low.
- R10: A soft reset clears the counter, the staged and alarm bytes, control, enable, status and key registers, and leaves the backup byte (0x100) unchanged.
- R11: Addresses that map to no register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| por_n | input | 1 | Asynchronous power-on reset, active low, clears everything |
| srst_n | input | 1 | Synchronous soft reset, active low, spares the backup byte |
| bus_addr | input | 12 | Byte address of a read or write |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick | input | 1 | One-cycle seconds pulse |
| clk_err_in | input | 1 | Clock-error condition from the oscillator monitor |
| clk32_in | input | 1 | 32 kHz clock routed to the pin in mode 3 |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Multi-purpose pin output |

## Verification
An alarm match and a software clear of the status byte can fall in the same cycle. The bench provokes this by placing the counter one below the alarm value. It then issues the status write with bit 0 set in the very cycle that carries the tick. The bit must read as set afterwards, and a second clear one cycle later must remove it. A second collision is a load write that meets a tick in the same cycle. There the counter must hold the staged value, with no increment on top.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 32;
  localparam int LANES  = CNT_W / 8;

  localparam logic [ADDR_W-1:0] A_CTL   = 12'h000;
  localparam logic [ADDR_W-1:0] A_LOAD  = 12'h004;
  localparam logic [ADDR_W-1:0] A_IEN   = 12'h008;
  localparam logic [ADDR_W-1:0] A_STA   = 12'h00C;
  localparam logic [ADDR_W-1:0] A_TIME  = 12'h020;
  localparam logic [ADDR_W-1:0] A_ALRM  = 12'h030;
  localparam logic [ADDR_W-1:0] A_KEY   = 12'h0FC;
  localparam logic [ADDR_W-1:0] A_BAK   = 12'h100;
  localparam logic [ADDR_W-1:0] A_CNT   = 12'h800;

  localparam logic [1:0] PIN_ALARM = 2'd2;
  localparam logic [1:0] PIN_CLK32 = 2'd3;

  // address of byte lane i of a value spread at a four-byte stride
  function automatic logic [ADDR_W-1:0] lane_addr(input logic [ADDR_W-1:0] base, input int i);
    return base + ADDR_W'(4 * i);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  // interrupt request from status and enable bytes
  function automatic logic irq_of(input logic [2:0] sta, input logic [2:0] en);
    return (sta[0] & en[0]) | (sta[2] & en[2]);
  endfunction
endpackage

// File: rtl/rtc_wrkey.sv
module rtc_wrkey
  import rtc_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hAC
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              srst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        key_q,
  output logic              wr_ok
);
  logic key_sel;
  assign key_sel = (bus_addr == A_KEY);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 key_q <= '0;
    else if (!srst_n)           key_q <= '0;
    else if (bus_wr && key_sel) key_q <= bus_wdata;
  end

  // key register itself is always writable; everything else needs the key
  assign wr_ok = bus_wr && !key_sel && (key_q == KEY);
endmodule

// File: rtl/rtc_time.sv
module rtc_time
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              srst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_ok,
  input  logic [7:0]        bus_wdata,
  input  logic              tick,
  input  logic              cnt_en,
  output logic [CNT_W-1:0]  stage_q,
  output logic [CNT_W-1:0]  alarm_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              load,
  output logic              step,
  output logic              match
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        stage_q[8*i +: 8] <= '0;
        alarm_q[8*i +: 8] <= '0;
      end else if (!srst_n) begin
        stage_q[8*i +: 8] <= '0;
        alarm_q[8*i +: 8] <= '0;
      end else if (wr_ok) begin
        if (bus_addr == lane_addr(A_TIME, i)) stage_q[8*i +: 8] <= bus_wdata;
        if (bus_addr == lane_addr(A_ALRM, i)) alarm_q[8*i +: 8] <= bus_wdata;
      end
    end
  end

  assign load  = wr_ok && (bus_addr == A_LOAD) && bus_wdata[0];
  assign step  = tick && cnt_en;
  assign match = step && !load && (next_count(cnt_q) == alarm_q);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cnt_q <= '0;
    else if (!srst_n) cnt_q <= '0;
    else if (load)    cnt_q <= stage_q;
    else if (step)    cnt_q <= next_count(cnt_q);
  end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       srst_n,
  input  logic       ev_alarm,
  input  logic       ev_pin,
  input  logic       clk_err_in,
  input  logic       clr_wr,
  input  logic [7:0] bus_wdata,
  input  logic [2:0] en_q,
  output logic [2:0] sta_q,
  output logic       irq
);
  logic [2:0] set_v;
  logic [2:0] clr_v;
  assign set_v = {clk_err_in, ev_pin, ev_alarm};
  assign clr_v = clr_wr ? bus_wdata[2:0] : 3'b000;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       sta_q <= '0;
    else if (!srst_n) sta_q <= '0;
    else              sta_q <= (sta_q & ~clr_v) | set_v;
  end

  assign irq = irq_of(sta_q, en_q);
endmodule

// File: rtl/rtc_keyreg.sv
module rtc_keyreg
  import rtc_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hAC
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              srst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick,
  input  logic              clk_err_in,
  input  logic              clk32_in,
  output logic              irq,
  output logic              pin_out
);
  logic [7:0]       key_q;
  logic             wr_ok;
  logic [7:0]       ctl_q;
  logic [2:0]       ien_q;
  logic [7:0]       bak_q;
  logic [CNT_W-1:0] stage_q, alarm_q, cnt_q;
  logic             load, step, match;
  logic             alarm_hit, pin_hit;
  logic [2:0]       sta_q;
  logic [1:0]       pin_mode;

  rtc_wrkey #(.KEY(KEY)) u_key (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .key_q(key_q), .wr_ok(wr_ok)
  );

  rtc_time u_time (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .bus_addr(bus_addr),
    .wr_ok(wr_ok), .bus_wdata(bus_wdata), .tick(tick), .cnt_en(ctl_q[0]),
    .stage_q(stage_q), .alarm_q(alarm_q), .cnt_q(cnt_q),
    .load(load), .step(step), .match(match)
  );

  assign pin_mode  = ctl_q[5:4];
  assign alarm_hit = match && ctl_q[2];
  assign pin_hit   = alarm_hit && (pin_mode == PIN_ALARM);

  rtc_irq u_irq (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .ev_alarm(alarm_hit),
    .ev_pin(pin_hit), .clk_err_in(clk_err_in),
    .clr_wr(wr_ok && (bus_addr == A_STA)), .bus_wdata(bus_wdata),
    .en_q(ien_q), .sta_q(sta_q), .irq(irq)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctl_q <= '0;
      ien_q <= '0;
    end else if (!srst_n) begin
      ctl_q <= '0;
      ien_q <= '0;
    end else if (wr_ok) begin
      if (bus_addr == A_CTL) ctl_q <= bus_wdata;
      if (bus_addr == A_IEN) ien_q <= bus_wdata[2:0];
    end
  end

  // backup byte: power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                            bak_q <= '0;
    else if (wr_ok && bus_addr == A_BAK)   bak_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL:   bus_rdata = {24'd0, ctl_q};
      A_IEN:   bus_rdata = {29'd0, ien_q};
      A_STA:   bus_rdata = {29'd0, sta_q};
      A_KEY:   bus_rdata = {24'd0, key_q};
      A_BAK:   bus_rdata = {24'd0, bak_q};
      A_CNT:   bus_rdata = cnt_q;
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < LANES; i++) begin
      if (bus_addr == lane_addr(A_TIME, i)) bus_rdata = {24'd0, stage_q[8*i +: 8]};
      if (bus_addr == lane_addr(A_ALRM, i)) bus_rdata = {24'd0, alarm_q[8*i +: 8]};
    end
  end

  always_comb begin
    case (pin_mode)
      PIN_ALARM: pin_out = sta_q[1];
      PIN_CLK32: pin_out = clk32_in;
      default:   pin_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/rtc_keyreg_chk.sv
module rtc_keyreg_chk
  import rtc_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic             srst_n,
  input logic             bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]       key_q,
  input logic [7:0]       ctl_q,
  input logic [7:0]       bak_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] stage_q,
  input logic             load,
  input logic             step,
  input logic             alarm_hit,
  input logic [2:0]       sta_q,
  input logic [2:0]       ien_q,
  input logic             clk_err_in,
  input logic             irq
);
  // R1: while locked, a write to the control byte leaves it unchanged
  p_locked_drop_r1: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    (bus_wr && bus_addr == A_CTL && key_q != 8'hAC) |=> $stable(ctl_q));

  // R3: load copies the staged value
  p_load_copy_r3: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    load |=> (cnt_q == $past(stage_q)));

  // R4: a tick without load advances by one
  p_step_one_r4: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    (step && !load) |=> (cnt_q == $past(cnt_q) + 32'd1));

  // R4: no tick and no load keeps the counter
  p_hold_r4: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    (!step && !load) |=> $stable(cnt_q));

  // R5 and R7: an alarm event sets status bit 0 regardless of a clear
  p_alarm_set_r7: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    alarm_hit |=> sta_q[0]);

  // R6: clock error is recorded
  p_clk_err_r6: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    clk_err_in |=> sta_q[2]);

  // R8: an enabled pending status drives the interrupt
  p_irq_r8: assert property (@(posedge clk) disable iff (!por_n)
    ((sta_q[0] && ien_q[0]) || (sta_q[2] && ien_q[2])) |-> irq);

  // R10: soft reset spares the backup byte
  p_bak_keep_r10: assert property (@(posedge clk) disable iff (!por_n)
    !srst_n |=> $stable(bak_q));
endmodule

bind rtc_keyreg rtc_keyreg_chk u_chk (
  .clk(clk), .por_n(por_n), .srst_n(srst_n), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .key_q(key_q), .ctl_q(ctl_q), .bak_q(bak_q),
  .cnt_q(cnt_q), .stage_q(stage_q), .load(load), .step(step),
  .alarm_hit(alarm_hit), .sta_q(sta_q), .ien_q(ien_q),
  .clk_err_in(clk_err_in), .irq(irq)
);

// File: tb/rtc_keyreg_bench.sv
module rtc_keyreg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {address, write data, expected readback}
  localparam logic [51:0] VEC [NVEC] = '{
    {12'h020, 8'h44, 32'h44}, {12'h024, 8'h33, 32'h33},
    {12'h028, 8'h22, 32'h22}, {12'h02C, 8'h11, 32'h11},
    {12'h030, 8'h5A, 32'h5A}, {12'h034, 8'hA5, 32'hA5},
    {12'h038, 8'h0F, 32'h0F}, {12'h03C, 8'hF0, 32'hF0},
    {12'h000, 8'h30, 32'h30}, {12'h008, 8'h05, 32'h05},
    {12'h100, 8'h70, 32'h70}
  };

  logic clk = 0, por_n = 0, srst_n = 1;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 0;
  logic [7:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic tick = 0, clk_err_in = 0, clk32_in = 0;
  logic irq, pin_out;
  int checks = 0, errors = 0;
  bit done = 0;

  rtc_keyreg u_rtc_keyreg (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .clk_err_in(clk_err_in), .clk32_in(clk32_in),
    .irq(irq), .pin_out(pin_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle, optionally with a tick in the same cycle
  task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic t = 0);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1; tick = t;
    @(negedge clk);
    bus_wr = 0; tick = 0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic load_time(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(12'h020 + 12'(4*i), v[8*i +: 8]);
    wr(12'h004, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    // reset state
    rd("R10 reset cnt", 12'h800, 0);
    rd("R1 reset key", 12'h0FC, 0);
    chk("R8 reset irq", {31'd0, irq}, 0);
    chk("R9 reset pin", {31'd0, pin_out}, 0);

    // R1: locked writes dropped
    wr(12'h000, 8'h05);
    rd("R1 locked ctl", 12'h000, 0);

    // R2: table walk
    wr(12'h0FC, 8'hAC);
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][51:40], VEC[k][39:32]);
      rd("R2 readback", VEC[k][51:40], VEC[k][31:0]);
    end

    // R1: relock then write is ignored
    wr(12'h0FC, 8'h00);
    wr(12'h020, 8'h99);
    rd("R1 relocked stage", 12'h020, 32'h44);
    wr(12'h004, 8'h01);
    rd("R1 locked load", 12'h800, 0);
    wr(12'h0FC, 8'hAC);

    // R3: load
    load_time(32'h1122_3344);
    rd("R3 load", 12'h800, 32'h1122_3344);

    // R4: counting
    wr(12'h000, 8'h01);
    repeat (3) pulse_tick();
    rd("R4 count", 12'h800, 32'h1122_3347);
    wr(12'h000, 8'h00);
    pulse_tick();
    rd("R4 hold", 12'h800, 32'h1122_3347);
    wr(12'h000, 8'h01);
    wr(12'h004, 8'h01, 1);
    rd("R4 load wins", 12'h800, 32'h1122_3344);

    // R5: alarm disabled gives no status
    for (int i = 0; i < 4; i++) wr(12'h030 + 12'(4*i), i == 0 ? 8'h45 : (i == 1 ? 8'h33 : (i == 2 ? 8'h22 : 8'h11)));
    pulse_tick();
    rd("R5 disabled", 12'h00C, 0);

    // R5, R8, R9: alarm with pin mode 2
    load_time(32'h1122_3343);
    wr(12'h008, 8'h01);
    wr(12'h000, 8'h25);
    pulse_tick();
    rd("R5 no early hit", 12'h00C, 0);
    pulse_tick();
    rd("R5 hit", 12'h00C, 3);
    chk("R8 irq alarm", {31'd0, irq}, 1);
    chk("R9 pin alarm", {31'd0, pin_out}, 1);

    // R7: clear bits
    wr(12'h00C, 8'h01);
    rd("R7 clear bit0", 12'h00C, 2);
    chk("R8 irq cleared", {31'd0, irq}, 0);
    wr(12'h00C, 8'h02);
    rd("R7 clear bit1", 12'h00C, 0);
    chk("R9 pin low", {31'd0, pin_out}, 0);

    // R7: set beats clear in the same cycle
    load_time(32'h1122_3344);
    wr(12'h00C, 8'h01, 1);
    rd("R7 set wins", 12'h00C, 3);
    wr(12'h00C, 8'h03);
    rd("R7 later clear", 12'h00C, 0);

    // R6, R8: clock error sticky, enable bit 2
    @(negedge clk); clk_err_in = 1;
    @(negedge clk); clk_err_in = 0;
    @(negedge clk);
    rd("R6 sticky", 12'h00C, 4);
    chk("R8 err masked", {31'd0, irq}, 0);
    wr(12'h008, 8'h04);
    chk("R8 err enabled", {31'd0, irq}, 1);
    wr(12'h00C, 8'h04);

    // R9: pin mode 3 and mode 0
    wr(12'h000, 8'h30);
    clk32_in = 1; #1;
    chk("R9 clk32 high", {31'd0, pin_out}, 1);
    clk32_in = 0; #1;
    chk("R9 clk32 low", {31'd0, pin_out}, 0);
    wr(12'h000, 8'h00);
    clk32_in = 1; #1;
    chk("R9 mode0", {31'd0, pin_out}, 0);
    clk32_in = 0;

    // R11: unmapped
    rd("R11 unmapped", 12'h044, 0);
    rd("R11 unmapped hi", 12'h804, 0);

    // R10: soft reset
    wr(12'h100, 8'hA0);
    @(negedge clk); srst_n = 0;
    @(negedge clk); srst_n = 1;
    rd("R10 backup kept", 12'h100, 32'hA0);
    rd("R10 cnt cleared", 12'h800, 0);
    rd("R10 key cleared", 12'h0FC, 0);
    rd("R10 stage cleared", 12'h020, 0);
    rd("R10 ctl cleared", 12'h000, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule